// File: doc/BRIEF.md
# Audio Codec Power-Up and Configuration Sequencer

This block brings an audio codec from cold to configured after a single start pulse. It turns on the codec supply and the audio path, releases the mute line and selects the 44.1 kHz external sample clock. It holds the codec in reset while the supply settles, then releases reset and waits for the codec to wake. The wait lengths are parameters counted in system clock cycles.

Once the codec is awake, the sequencer plays out a fixed list of thirteen configuration writes through a write-master port for a three-wire L3 control bus. The first write carries the codec's soft-reset bit. The sequencer then pulses the codec reset line and writes the status register again with the reset bit cleared. The direct writes that follow set status, volume, tone and peak detection. Six extended writes of two data bytes each finish the list. When the last write has completed, a ready flag goes high and stays high until reset.

The request side of the port follows valid/ready rules. A request, made of an address byte, one or two data bytes and a length flag, stays stable while `l3_valid` is high and `l3_ready` is low. It is accepted in the cycle where both are high. Completion is reported separately by a `l3_done` pulse, and only one write is ever outstanding.

Top module: `codec_bringup_seq`

## Requirements
- R1: While reset is held and afterwards until start, `pwr_on`, `aud_en`, `clk_sel0`, `clk_sel1`, `codec_rst_n`, `l3_valid` and `cfg_ready` are low and `mute_o` is high.
- R2: In the cycle after `start` is sampled high in idle, `pwr_on`, `aud_en` and `clk_sel0` go high while `mute_o`, `clk_sel1` and `codec_rst_n` are low. Supply, enable, mute and clock-select levels then hold until reset.
- R3: `codec_rst_n` rises exactly PWR_WAIT_CYC cycles after `pwr_on` rises.
- R4: The first request (`l3_valid` high) appears exactly WAKE_WAIT_CYC cycles after `codec_rst_n` rises. No request is ever presented while `codec_rst_n` is low.
- R5: While `l3_valid` is high and `l3_ready` is low, the request fields hold steady. `l3_valid` is low in the cycle after the handshake.
- R6: A new request is presented in the cycle after a `l3_done` that arrives after the handshake of the outstanding write. A `l3_done` in the handshake cycle itself is ignored.
- R7: The requests come in this order (two = `l3_two`, addr, data0, data1), with data1 = 0x00 for one-byte writes. First come the direct writes: (0,0x16,0x62), (0,0x16,0x22), (0,0x16,0x22), (0,0x16,0xE0), (0,0x14,0x0A), (0,0x14,0x40), (0,0x14,0xA0). Then come the extended writes (1,0x14,0xC0+k,0xE0+v), k = 0..5, with v = 4, 4, 30, 0, 0, 0.
- R8: After the first write completes, `codec_rst_n` is low for exactly RST_PULSE_CYC cycles. The second request appears in the cycle it rises again, and the reset line is not pulsed again.
- R9: `cfg_ready` rises in the cycle after the last write's `l3_done`. It then stays high with no further requests.
- R10: `start` pulses during the sequence or after `cfg_ready` have no effect on the outputs or on the request stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin the bring-up (honoured only in idle) |
| pwr_on | output | 1 | Codec supply enable |
| aud_en | output | 1 | Audio path / amplifier enable |
| mute_o | output | 1 | Mute line, high = muted |
| codec_rst_n | output | 1 | Codec reset, active low |
| clk_sel0 | output | 1 | Sample-clock select bit 0 |
| clk_sel1 | output | 1 | Sample-clock select bit 1 |
| l3_valid | output | 1 | Write request valid |
| l3_ready | input | 1 | Bus master accepts request |
| l3_addr | output | 8 | Address byte |
| l3_data0 | output | 8 | First data byte |
| l3_data1 | output | 8 | Second data byte (two-byte writes) |
| l3_two | output | 1 | 1 = two data bytes, 0 = one |
| l3_done | input | 1 | Pulse: outstanding write finished on the bus |
| cfg_ready | output | 1 | Configuration complete |

## Verification
The delicate collision is between the handshake and completion. A `l3_done` pulse can coincide with the cycle in which a request is accepted. The bench provokes this on the very first write: it raises `l3_done` together with `l3_ready`. It then judges that neither the reset pulse nor the next request appears until a later genuine `l3_done`. A second overlap is a `start` pulse landing while a write is outstanding and again after `cfg_ready`. A scoreboard of the expected thirteen writes shows that no request is added, dropped or reordered.

// File: rtl/codec_bu_pkg.sv
`timescale 1ns/1ps
package codec_bu_pkg;

  localparam int NUM_DIRECT = 7;
  localparam int NUM_EXT    = 6;
  localparam int NUM_WRITES = NUM_DIRECT + NUM_EXT;
  localparam int IDXW       = $clog2(NUM_WRITES);

  typedef struct packed {
    logic       two;
    logic [7:0] addr;
    logic [7:0] d0;
    logic [7:0] d1;
  } l3_wr_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PWR,
    ST_WAKE,
    ST_WAIT,
    ST_RSTP,
    ST_DONE
  } seq_st_e;

endpackage

// File: rtl/cbs_wait_timer.sv
`timescale 1ns/1ps
module cbs_wait_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  AST_TMR_REST: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && expired) |=> expired); // R3

endmodule

// File: rtl/cbs_write_table.sv
`timescale 1ns/1ps
module cbs_write_table
  import codec_bu_pkg::*;
#(
  parameter logic [7:0] ADDR_STATUS   = 8'h16,
  parameter logic [7:0] ADDR_DATA     = 8'h14,
  parameter logic [7:0] ST0_CFG       = 8'h22,
  parameter logic [7:0] ST0_RST_BIT   = 8'h40,
  parameter logic [7:0] ST1_BYTE      = 8'hE0,
  parameter logic [5:0] VOL_CODE      = 6'd10,
  parameter logic [7:0] DATA1_BYTE    = 8'h40,
  parameter logic [7:0] DATA2_BYTE    = 8'hA0,
  parameter logic [7:0] EXT_ADDR_BASE = 8'hC0,
  parameter logic [7:0] EXT_DATA_BASE = 8'hE0,
  parameter logic [NUM_EXT*5-1:0] EXT_VALS = {5'd0, 5'd0, 5'd0, 5'd30, 5'd4, 5'd4}
) (
  input  logic [IDXW-1:0] idx,
  output l3_wr_t          wr
);

  l3_wr_t ext_tab [NUM_EXT];

  for (genvar g = 0; g < NUM_EXT; g++) begin : g_ext
    assign ext_tab[g].two  = 1'b1;
    assign ext_tab[g].addr = ADDR_DATA;
    assign ext_tab[g].d0   = EXT_ADDR_BASE | 8'(g);
    assign ext_tab[g].d1   = EXT_DATA_BASE | {3'b000, EXT_VALS[g*5 +: 5]};
  end

  logic [IDXW-1:0] ext_off;
  logic [2:0]      ext_sel;

  always_comb begin
    ext_off = idx - IDXW'(NUM_DIRECT);
    ext_sel = ext_off[2:0];
    wr      = '0;
    case (idx)
      IDXW'(0): wr = '{two: 1'b0, addr: ADDR_STATUS, d0: ST0_CFG | ST0_RST_BIT, d1: 8'h00};
      IDXW'(1),
      IDXW'(2): wr = '{two: 1'b0, addr: ADDR_STATUS, d0: ST0_CFG, d1: 8'h00};
      IDXW'(3): wr = '{two: 1'b0, addr: ADDR_STATUS, d0: ST1_BYTE, d1: 8'h00};
      IDXW'(4): wr = '{two: 1'b0, addr: ADDR_DATA, d0: {2'b00, VOL_CODE}, d1: 8'h00};
      IDXW'(5): wr = '{two: 1'b0, addr: ADDR_DATA, d0: DATA1_BYTE, d1: 8'h00};
      IDXW'(6): wr = '{two: 1'b0, addr: ADDR_DATA, d0: DATA2_BYTE, d1: 8'h00};
      default: begin
        if (idx < IDXW'(NUM_WRITES)) wr = ext_tab[ext_sel];
      end
    endcase
  end

endmodule

// File: rtl/cbs_l3_port.sv
`timescale 1ns/1ps
module cbs_l3_port
  import codec_bu_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   issue,
  input  l3_wr_t desc_i,
  input  logic   l3_ready,
  input  logic   l3_done,
  output logic   l3_valid,
  output l3_wr_t req_o,
  output logic   complete
);

  logic pending;

  assign complete = pending && l3_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l3_valid <= 1'b0;
      pending  <= 1'b0;
      req_o    <= '0;
    end else begin
      if (issue) begin
        l3_valid <= 1'b1;
        req_o    <= desc_i;
      end else if (l3_valid && l3_ready) begin
        l3_valid <= 1'b0;
        pending  <= 1'b1;
      end
      if (complete) pending <= 1'b0;
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (l3_valid && !l3_ready) |=> (l3_valid && $stable(req_o))); // R5

  AST_DROP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (l3_valid && l3_ready) |=> !l3_valid); // R5

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> (!l3_valid && (!pending || l3_done))); // R6

endmodule

// File: rtl/codec_bringup_seq.sv
`timescale 1ns/1ps
module codec_bringup_seq
  import codec_bu_pkg::*;
#(
  parameter int PWR_WAIT_CYC  = 10_000_000,
  parameter int WAKE_WAIT_CYC = 10_000_000,
  parameter int RST_PULSE_CYC = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output logic       pwr_on,
  output logic       aud_en,
  output logic       mute_o,
  output logic       codec_rst_n,
  output logic       clk_sel0,
  output logic       clk_sel1,
  output logic       l3_valid,
  input  logic       l3_ready,
  output logic [7:0] l3_addr,
  output logic [7:0] l3_data0,
  output logic [7:0] l3_data1,
  output logic       l3_two,
  input  logic       l3_done,
  output logic       cfg_ready
);

  localparam int MAXW = (PWR_WAIT_CYC > WAKE_WAIT_CYC)
                      ? ((PWR_WAIT_CYC > RST_PULSE_CYC) ? PWR_WAIT_CYC : RST_PULSE_CYC)
                      : ((WAKE_WAIT_CYC > RST_PULSE_CYC) ? WAKE_WAIT_CYC : RST_PULSE_CYC);
  localparam int CW = $clog2(MAXW + 1);
  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(NUM_WRITES - 1);

  seq_st_e         state, nstate;
  logic [IDXW-1:0] idx, nidx;
  logic            issue, t_load, t_exp, complete;
  logic [CW-1:0]   t_val;
  l3_wr_t          desc, req;

  cbs_wait_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .expired  (t_exp)
  );

  cbs_write_table u_table (
    .idx (nidx),
    .wr  (desc)
  );

  cbs_l3_port u_port (
    .clk      (clk),
    .rst_n    (rst_n),
    .issue    (issue),
    .desc_i   (desc),
    .l3_ready (l3_ready),
    .l3_done  (l3_done),
    .l3_valid (l3_valid),
    .req_o    (req),
    .complete (complete)
  );

  always_comb begin
    nstate = state;
    nidx   = idx;
    issue  = 1'b0;
    t_load = 1'b0;
    t_val  = '0;
    case (state)
      ST_IDLE: if (start) begin
        nstate = ST_PWR;
        t_load = 1'b1;
        t_val  = CW'(PWR_WAIT_CYC - 1);
      end
      ST_PWR: if (t_exp) begin
        nstate = ST_WAKE;
        t_load = 1'b1;
        t_val  = CW'(WAKE_WAIT_CYC - 1);
      end
      ST_WAKE: if (t_exp) begin
        nidx   = '0;
        issue  = 1'b1;
        nstate = ST_WAIT;
      end
      ST_WAIT: if (complete) begin
        if (idx == '0) begin
          nstate = ST_RSTP;
          t_load = 1'b1;
          t_val  = CW'(RST_PULSE_CYC - 1);
        end else if (idx == LAST_IDX) begin
          nstate = ST_DONE;
        end else begin
          nidx  = idx + 1'b1;
          issue = 1'b1;
        end
      end
      ST_RSTP: if (t_exp) begin
        nidx   = idx + 1'b1;
        issue  = 1'b1;
        nstate = ST_WAIT;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx   <= '0;
    end else begin
      state <= nstate;
      idx   <= nidx;
    end
  end

  assign pwr_on      = (state != ST_IDLE);
  assign aud_en      = (state != ST_IDLE);
  assign mute_o      = (state == ST_IDLE);
  assign clk_sel0    = (state != ST_IDLE);
  assign clk_sel1    = 1'b0;
  assign codec_rst_n = !(state inside {ST_IDLE, ST_PWR, ST_RSTP});
  assign cfg_ready   = (state == ST_DONE);

  assign l3_addr  = req.addr;
  assign l3_data0 = req.d0;
  assign l3_data1 = req.d1;
  assign l3_two   = req.two;

  AST_NO_EARLY_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    l3_valid |-> (codec_rst_n && pwr_on)); // R4

  AST_PWR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_on |=> (pwr_on && aud_en && !mute_o && clk_sel0)); // R2

  AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ready |=> cfg_ready); // R9

  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ready |-> !l3_valid); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |-> (!l3_valid && !codec_rst_n && mute_o)); // R1

endmodule

// File: tb/codec_bringup_seq_tb_top.sv
`timescale 1ns/1ps
module codec_bringup_seq_tb_top;

  localparam int PWR_W  = 20;
  localparam int WAKE_W = 15;
  localparam int PULSE  = 4;
  localparam int LIMIT  = 20000;

  logic clk = 1'b0;
  logic rst_n, start, l3_ready, l3_done;
  logic pwr_on, aud_en, mute_o, codec_rst_n, clk_sel0, clk_sel1;
  logic l3_valid, l3_two, cfg_ready;
  logic [7:0] l3_addr, l3_data0, l3_data1;

  int tests = 0;
  int fails = 0;
  bit finished = 0;
  logic [24:0] exp_q [$];

  always #5 clk = ~clk;

  codec_bringup_seq #(
    .PWR_WAIT_CYC  (PWR_W),
    .WAKE_WAIT_CYC (WAKE_W),
    .RST_PULSE_CYC (PULSE)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .pwr_on(pwr_on), .aud_en(aud_en), .mute_o(mute_o),
    .codec_rst_n(codec_rst_n), .clk_sel0(clk_sel0), .clk_sel1(clk_sel1),
    .l3_valid(l3_valid), .l3_ready(l3_ready), .l3_addr(l3_addr),
    .l3_data0(l3_data0), .l3_data1(l3_data1), .l3_two(l3_two),
    .l3_done(l3_done), .cfg_ready(cfg_ready)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push_wr(input bit two, input logic [7:0] a, input logic [7:0] d0,
                         input logic [7:0] d1);
    exp_q.push_back({two, a, d0, d1});
  endtask

  // Driver: expected write list built from R7
  task automatic push_expected();
    push_wr(0, 8'h16, 8'h62, 8'h00);
    push_wr(0, 8'h16, 8'h22, 8'h00);
    push_wr(0, 8'h16, 8'h22, 8'h00);
    push_wr(0, 8'h16, 8'hE0, 8'h00);
    push_wr(0, 8'h14, 8'h0A, 8'h00);
    push_wr(0, 8'h14, 8'h40, 8'h00);
    push_wr(0, 8'h14, 8'hA0, 8'h00);
    push_wr(1, 8'h14, 8'hC0, 8'hE4);
    push_wr(1, 8'h14, 8'hC1, 8'hE4);
    push_wr(1, 8'h14, 8'hC2, 8'hFE);
    push_wr(1, 8'h14, 8'hC3, 8'hE0);
    push_wr(1, 8'h14, 8'hC4, 8'hE0);
    push_wr(1, 8'h14, 8'hC5, 8'hE0);
  endtask

  // Monitor: compare each accepted request with the scoreboard (R7)
  always @(negedge clk) begin
    if (rst_n === 1'b1 && l3_valid && l3_ready) begin
      logic [24:0] got, exp;
      got = {l3_two, l3_addr, l3_data0, l3_data1};
      if (exp_q.size() == 0) begin
        check(0, "R7", "unexpected write", int'(got), 0);
      end else begin
        exp = exp_q.pop_front();
        check(got == exp, "R7", "write contents", int'(got), int'(exp));
      end
    end
  end

  task automatic serve(input int k);
    logic [7:0] a0, d00;
    int c;
    c = 0;
    while (!l3_valid && c < 100) begin tick(); c++; end
    check(l3_valid, "R6", "request present", l3_valid, 1);
    a0 = l3_addr; d00 = l3_data0;
    for (int i = 0; i < k % 3; i++) begin
      tick();
      check(l3_valid && l3_addr == a0 && l3_data0 == d00, "R5", "held request",
            {l3_valid, l3_addr, l3_data0}, {1'b1, a0, d00});
    end
    l3_ready = 1'b1;
    l3_done  = (k == 0);   // stray done coincides with the handshake
    tick();
    l3_ready = 1'b0;
    l3_done  = 1'b0;
    check(!l3_valid, "R5", "valid drops after accept", l3_valid, 0);
    if (k >= 1) check(codec_rst_n, "R8", "no second reset pulse", codec_rst_n, 1);
    if (k == 0) begin
      for (int i = 0; i < 3; i++) begin
        tick();
        check(!l3_valid && codec_rst_n, "R6", "done in accept cycle ignored",
              {l3_valid, codec_rst_n}, 2'b01);
      end
    end
    if (k == 5) begin
      start = 1'b1; tick(); start = 1'b0;   // R10 start while busy
    end
    for (int i = 0; i < k % 2; i++) tick();
    l3_done = 1'b1;
    tick();
    l3_done = 1'b0;
    if (k == 0) begin
      c = 0;
      while (!codec_rst_n && c < 100) begin tick(); c++; end
      check(c == PULSE, "R8", "reset pulse width", c, PULSE);
      check(l3_valid, "R8", "second request at reset release", l3_valid, 1);
    end else if (k < 12) begin
      check(l3_valid, "R6", "next request after done", l3_valid, 1);
    end else begin
      check(cfg_ready && !l3_valid, "R9", "ready after last done",
            {cfg_ready, l3_valid}, 2'b10);
    end
  endtask

  initial begin
    int c;
    rst_n = 1'b0; start = 1'b0; l3_ready = 1'b0; l3_done = 1'b0;
    repeat (3) tick();
    check({pwr_on, aud_en, mute_o, codec_rst_n, clk_sel0, clk_sel1, l3_valid, cfg_ready}
          == 8'b00100000, "R1", "outputs in reset",
          {pwr_on, aud_en, mute_o, codec_rst_n, clk_sel0, clk_sel1, l3_valid, cfg_ready},
          8'b00100000);
    rst_n = 1'b1;
    repeat (5) tick();
    check({pwr_on, aud_en, mute_o, codec_rst_n, clk_sel0, clk_sel1, l3_valid, cfg_ready}
          == 8'b00100000, "R1", "idle before start",
          {pwr_on, aud_en, mute_o, codec_rst_n, clk_sel0, clk_sel1, l3_valid, cfg_ready},
          8'b00100000);
    push_expected();
    start = 1'b1; tick(); start = 1'b0;
    check({pwr_on, aud_en, mute_o, codec_rst_n, clk_sel0, clk_sel1} == 6'b110010,
          "R2", "power-up levels",
          {pwr_on, aud_en, mute_o, codec_rst_n, clk_sel0, clk_sel1}, 6'b110010);
    c = 0;
    while (!codec_rst_n && c < 1000) begin tick(); c++; end
    check(c == PWR_W, "R3", "power wait", c, PWR_W);
    c = 0;
    while (!l3_valid && c < 1000) begin tick(); c++; end
    check(c == WAKE_W, "R4", "wake wait", c, WAKE_W);
    for (int k = 0; k < 13; k++) serve(k);
    check(exp_q.size() == 0, "R7", "all writes seen", exp_q.size(), 0);
    start = 1'b1; tick(); start = 1'b0;
    for (int i = 0; i < 30; i++) begin
      tick();
      if (l3_valid || !cfg_ready || !pwr_on || mute_o || !codec_rst_n)
        check(0, "R10", "start after ready changed state",
              {l3_valid, cfg_ready, pwr_on, mute_o, codec_rst_n}, 5'b01101);
    end
    check(cfg_ready && pwr_on && !l3_valid && clk_sel0 && !clk_sel1, "R10",
          "state unchanged by late start",
          {cfg_ready, pwr_on, l3_valid, clk_sel0, clk_sel1}, 5'b11010);
    check(exp_q.size() == 0 && cfg_ready, "R9", "ready stays, no extra writes",
          {exp_q.size(), cfg_ready}, 1);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(LIMIT * 10);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule